// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of a byte-wide parallel flash and turns one high-level request into the bus cycles the flash expects. A request carries an operation code, an address and a data byte, and is taken on a valid/ready handshake. The sequencer then emits the unlock writes that guard the chosen operation. For a program or an erase, it polls the flash until the toggling status bit settles. For a program, it also reads the target byte back and compares it with the requested data. The result comes back as a one-cycle response carrying a status code and the bytes read.

The flash side is abstracted to one transfer per handshake. `bus_valid` holds a read or a write until the flash side answers with `bus_ready`, and read data arrives with that answer. Electrical timing is left to whatever adapter sits between this port and the pins. A poll limit, set by a parameter, turns a flash that never settles into a timeout status instead of a hang.

Top module: `flash_seq`

## Requirements
- R1: While reset is asserted and just after it is released, `req_ready` is 1, `bus_valid` is 0 and `rsp_valid` is 0.
- R2: Operation code 0 (program) writes, in order, AAh to 5555h, 55h to 2AAAh, A0h to 5555h, and then the request data to the request address.
- R3: Operation code 1 (sector erase) writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, and then 30h to the request address with its low SECT_BITS bits cleared.
- R4: Operation code 2 (chip erase) writes the same first five cycles as R3, and then 10h to 5555h.
- R5: Operation code 3 (identify) writes AAh@5555h, 55h@2AAAh and 90h@5555h. It then reads address 0 and address 1, and ends with a single write of F0h. It makes no further reads and responds with status 0 and `rsp_data` = {byte read at 1, byte read at 0}.
- R6: After the final write of a program or erase has completed, the sequencer reads the poll address. That address is the target for a program, the cleared sector address for a sector erase, and 5555h for a chip erase. The flash counts as settled once one read matches the read before it in bit 6 and two further reads match as well. If one of those two further reads differs, polling resumes.
- R7: Each poll read whose bit 6 differs from the read before it counts toward a limit. The MAX_POLLS-th such read ends the request with status 1 (timeout), so a flash that never settles gives exactly MAX_POLLS+1 poll reads.
- R8: Once a program has settled, the target byte is read back. If that read equals the data, the status is 0. Otherwise two more reads follow, and the status is 2 (mismatch) only if both of them differ from the data as well. `rsp_data[7:0]` is the last byte read.
- R9: `req_ready` is low from the cycle after a request is accepted until `rsp_valid` has been pulsed. A request presented during that time has no effect on the bus cycles issued.
- R10: `rsp_valid` is a single-cycle pulse. Its status is one of 0, 1 or 2, and `req_ready` is high in the cycle after it.
- R11: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 identify |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 ok, 1 timeout, 2 verify mismatch |
| rsp_data | output | 16 | Identify bytes, or last byte read in the low half |
| bus_valid | output | 1 | Flash transfer pending |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | 8 | Flash write data |
| bus_ready | input | 1 | Flash side completes the transfer |
| bus_rdata | input | 8 | Read data, valid with bus_ready |

## Verification
The bench scripts the flash's read responses for each request: a random run of toggling reads followed by a settled tail, with mismatching bytes mixed into the read-back. It also covers a false settle, where one equal pair is broken by a confirming read. A sequencer that declares completion on the first equal pair would report success too early and make fewer reads than expected. A flash that toggles forever checks the exact timeout read count, which exposes an off-by-one in the limit. Read-back cases where only the first read or all three reads mismatch separate a sequencer that fails on one bad read from one that retries. A sector erase address with low bits set catches a missing sector alignment. Requests offered while busy catch a sequencer that restarts mid-sequence.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int AW        = 19,
  parameter int SECT_BITS = 12,
  parameter int MAX_POLLS = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          rsp_valid,
  output logic [1:0]    rsp_status,
  output logic [15:0]   rsp_data,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic          bus_ready,
  input  logic [7:0]    bus_rdata
);
  localparam int PCW = $clog2(MAX_POLLS + 1);
  localparam logic [1:0] OP_PROG = 2'd0, OP_SECT = 2'd1, OP_ID = 2'd3;
  localparam logic [1:0] ST_OK = 2'd0, ST_TMO = 2'd1, ST_BAD = 2'd2;
  localparam logic [AW-1:0] A_HI = AW'(15'h5555);
  localparam logic [AW-1:0] A_LO = AW'(15'h2AAA);

  typedef enum logic [2:0] {IDLE, SEQ, PFIRST, POLL, CONF, VERIFY, FIN} phase_t;

  phase_t        phase;
  logic [1:0]    op;
  logic [AW-1:0] tgt;
  logic [7:0]    wval;
  logic [2:0]    step;
  logic          prev6;
  logic [PCW-1:0] pcnt;
  logic [1:0]    sub;
  logic          vbad;
  logic [7:0]    lo, hi;
  logic [1:0]    status;

  logic          s_wr;
  logic [AW-1:0] s_addr;
  logic [7:0]    s_data;

  wire xfer = bus_valid && bus_ready;
  wire [AW-1:0] sect_addr = {tgt[AW-1:SECT_BITS], {SECT_BITS{1'b0}}};
  wire [AW-1:0] poll_addr = (op == OP_PROG) ? tgt : (op == OP_SECT) ? sect_addr : A_HI;
  wire [2:0] last_step = (op == OP_PROG) ? 3'd3 : 3'd5;

  always_comb begin
    s_wr   = 1'b1;
    s_addr = A_HI;
    s_data = 8'hAA;
    case (step)
      3'd0: ;
      3'd1: begin s_addr = A_LO; s_data = 8'h55; end
      3'd2: s_data = (op == OP_PROG) ? 8'hA0 : (op == OP_ID) ? 8'h90 : 8'h80;
      3'd3:
        if (op == OP_PROG) begin s_addr = tgt; s_data = wval; end
        else if (op == OP_ID) begin s_wr = 1'b0; s_addr = '0; end
      3'd4:
        if (op == OP_ID) begin s_wr = 1'b0; s_addr = AW'(1); end
        else begin s_addr = A_LO; s_data = 8'h55; end
      default:
        if (op == OP_ID) begin s_addr = '0; s_data = 8'hF0; end
        else if (op == OP_SECT) begin s_addr = sect_addr; s_data = 8'h30; end
        else s_data = 8'h10;
    endcase
  end

  assign req_ready  = (phase == IDLE);
  assign rsp_valid  = (phase == FIN);
  assign rsp_status = status;
  assign rsp_data   = {hi, lo};
  assign bus_valid  = (phase != IDLE) && (phase != FIN);
  assign bus_write  = (phase == SEQ) && s_wr;
  assign bus_addr   = (phase == SEQ) ? s_addr : poll_addr;
  assign bus_wdata  = (phase == SEQ) ? s_data : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= IDLE;
      op     <= '0;
      tgt    <= '0;
      wval   <= '0;
      step   <= '0;
      prev6  <= 1'b0;
      pcnt   <= '0;
      sub    <= '0;
      vbad   <= 1'b0;
      lo     <= '0;
      hi     <= '0;
      status <= ST_OK;
    end else begin
      case (phase)
        IDLE:
          if (req_valid) begin
            op     <= req_op;
            tgt    <= req_addr;
            wval   <= req_data;
            step   <= '0;
            status <= ST_OK;
            lo     <= '0;
            hi     <= '0;
            phase  <= SEQ;
          end
        SEQ:
          if (xfer) begin
            if (op == OP_ID && step == 3'd3) lo <= bus_rdata;
            if (op == OP_ID && step == 3'd4) hi <= bus_rdata;
            if (step == last_step) phase <= (op == OP_ID) ? FIN : PFIRST;
            step <= step + 3'd1;
          end
        PFIRST:
          if (xfer) begin
            prev6 <= bus_rdata[6];
            lo    <= bus_rdata;
            pcnt  <= '0;
            phase <= POLL;
          end
        POLL, CONF:
          if (xfer) begin
            lo <= bus_rdata;
            if (bus_rdata[6] != prev6) begin
              prev6 <= bus_rdata[6];
              if (pcnt == PCW'(MAX_POLLS - 1)) begin
                status <= ST_TMO;
                phase  <= FIN;
              end else begin
                pcnt  <= pcnt + 1'b1;
                phase <= POLL;
              end
            end else if (phase == POLL) begin
              sub   <= 2'd0;
              phase <= CONF;
            end else if (sub == 2'd0) begin
              sub <= 2'd1;
            end else if (op == OP_PROG) begin
              sub   <= 2'd0;
              vbad  <= 1'b0;
              phase <= VERIFY;
            end else begin
              phase <= FIN;
            end
          end
        VERIFY:
          if (xfer) begin
            lo <= bus_rdata;
            if (sub == 2'd0) begin
              if (bus_rdata == wval) phase <= FIN;
              else sub <= 2'd1;
            end else if (sub == 2'd1) begin
              vbad <= (bus_rdata != wval);
              sub  <= 2'd2;
            end else begin
              if (vbad && bus_rdata != wval) status <= ST_BAD;
              phase <= FIN;
            end
          end
        default: phase <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [1:0]    rsp_status,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          bus_ready
);
  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_write) && $stable(bus_addr) && $stable(bus_wdata));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R9
  idle_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_valid && !rsp_valid);

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  // R10
  rsp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'b11);
endmodule

bind flash_seq flash_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_ready(bus_ready)
);

// File: tb/flash_seq_test.sv
module flash_seq_test;
  localparam int AW = 19, SB = 12, MAXP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          rsp_valid;
  logic [1:0]    rsp_status;
  logic [15:0]   rsp_data;
  logic          bus_valid, bus_write;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic          bus_ready = 1'b0;
  logic [7:0]    bus_rdata = '0;

  flash_seq #(.AW(AW), .SECT_BITS(SB), .MAX_POLLS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  int compared = 0, mismatched = 0;
  logic [7:0]    script [64];
  int            slen = 1;
  logic [7:0]    id0 = 8'h3C, id1 = 8'hD2;
  logic [1:0]    cur_op = '0;
  logic [AW-1:0] exp_paddr = '0;
  logic [AW-1:0] wa [16];
  logic [7:0]    wd [16];
  logic [AW-1:0] ea [6];
  logic [7:0]    ed [6];
  logic [AW-1:0] ra [4];
  int nw = 0, nr = 0, rdi = 0, badp = 0, ne = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // flash side: random wait, logs writes, answers reads from the script
  initial forever begin
    @(negedge clk);
    bus_ready = 1'b0;
    if (rst_n && bus_valid) begin
      repeat ($urandom % 3) @(negedge clk);
      if (bus_write) begin
        if (nw < 16) begin wa[nw] = bus_addr; wd[nw] = bus_wdata; end
        nw++;
        rdi = 0;
      end else begin
        if (nr < 4) ra[nr] = bus_addr;
        nr++;
        if (cur_op == 2'd3)
          bus_rdata = (bus_addr == '0) ? id0 : (bus_addr == AW'(1)) ? id1 : 8'hEE;
        else begin
          bus_rdata = script[rdi < slen ? rdi : slen - 1];
          rdi++;
          if (bus_addr != exp_paddr) badp++;
        end
      end
      bus_ready = 1'b1;
    end
  end

  function automatic logic [7:0] sv(input int i);
    return script[i < slen ? i : slen - 1];
  endfunction

  // expected outcome of polling and read-back, from R6/R7/R8
  function automatic void ref_poll(input logic [1:0] op, input logic [7:0] d,
                                   output logic [1:0] st, output logic [7:0] last, output int n);
    int i, pc, c;
    logic p;
    logic [7:0] v, w1;
    bit fin;
    v = sv(0); p = v[6]; last = v; i = 1; pc = 0; c = 0; st = 2'd0; fin = 0;
    while (!fin) begin
      last = sv(i); i++;
      if (last[6] != p) begin
        p = last[6]; c = 0;
        if (pc == MAXP - 1) begin st = 2'd1; fin = 1; end
        else pc++;
      end else if (c < 2) c++;
      else begin
        if (op == 2'd0) begin
          last = sv(i); i++;
          if (last != d) begin
            w1 = sv(i); i++;
            last = sv(i); i++;
            if (w1 != d && last != d) st = 2'd2;
          end
        end
        fin = 1;
      end
    end
    n = i;
  endfunction

  task automatic build_writes(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    ea[0] = AW'(15'h5555); ed[0] = 8'hAA;
    ea[1] = AW'(15'h2AAA); ed[1] = 8'h55;
    ea[2] = AW'(15'h5555);
    if (op == 2'd0) begin
      ed[2] = 8'hA0; ea[3] = a; ed[3] = d; ne = 4;
    end else if (op == 2'd3) begin
      ed[2] = 8'h90; ea[3] = '0; ed[3] = 8'hF0; ne = 4;
    end else begin
      ed[2] = 8'h80;
      ea[3] = AW'(15'h5555); ed[3] = 8'hAA;
      ea[4] = AW'(15'h2AAA); ed[4] = 8'h55;
      if (op == 2'd1) begin ea[5] = {a[AW-1:SB], {SB{1'b0}}}; ed[5] = 8'h30; end
      else begin ea[5] = AW'(15'h5555); ed[5] = 8'h10; end
      ne = 6;
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d, input bit poke);
    logic [1:0] est, gst;
    logic [7:0] elast;
    logic [15:0] gdata;
    int en, cyc;
    bit rdy_bad, wr_ok;
    string rq;
    nw = 0; nr = 0; rdi = 0; badp = 0; cur_op = op;
    exp_paddr = (op == 2'd0) ? a : (op == 2'd1) ? {a[AW-1:SB], {SB{1'b0}}} : AW'(15'h5555);
    rq = (op == 2'd0) ? "R2" : (op == 2'd1) ? "R3" : (op == 2'd2) ? "R4" : "R5";
    build_writes(op, a, d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    if (poke) begin req_op = ~op; req_addr = AW'($urandom); req_data = ~d; end
    else req_valid = 1'b0;
    rdy_bad = 0; cyc = 0;
    while (!rsp_valid && cyc < 3000) begin
      if (req_ready) rdy_bad = 1;
      @(negedge clk);
      cyc++;
    end
    gst = rsp_status; gdata = rsp_data;
    req_valid = 1'b0;
    chk(cyc < 3000, "R10", "response arrives", cyc, 0);
    chk(!rdy_bad, "R9", "ready low while busy", rdy_bad, 0);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10", "one-cycle pulse then ready", {rsp_valid, req_ready}, 2'b01);
    chk(nw == ne, rq, "write count", nw, ne);
    wr_ok = (nw == ne);
    for (int i = 0; i < ne && i < nw; i++) begin
      chk(wa[i] == ea[i] && wd[i] == ed[i], rq, $sformatf("write %0d", i),
          {wa[i], wd[i]}, {ea[i], ed[i]});
      if (wa[i] != ea[i] || wd[i] != ed[i]) wr_ok = 0;
    end
    if (poke) chk(wr_ok, "R9", "busy request ignored", nw, ne);
    if (op == 2'd3) begin
      chk(gst == 2'd0 && gdata == {id1, id0}, "R5", "identify response", {gst, gdata}, {2'b00, id1, id0});
      chk(nr == 2 && ra[0] == '0 && ra[1] == AW'(1), "R5", "identify reads", nr, 2);
    end else begin
      ref_poll(op, d, est, elast, en);
      rq = (est == 2'd1) ? "R7" : (op == 2'd0) ? "R8" : "R6";
      chk(gst == est, rq, "status", gst, est);
      chk(gdata == {8'h00, elast}, rq, "last byte", gdata, elast);
      chk(nr == en, "R6", "poll read count", nr, en);
      chk(badp == 0, "R6", "poll address", badp, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int b;
    logic [1:0] op;
    logic [7:0] d, v;
    logic t6;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) script[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_valid && !rsp_valid, "R1", "in reset", {req_ready, bus_valid, rsp_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_valid && !rsp_valid, "R1", "after reset", {req_ready, bus_valid, rsp_valid}, 3'b100);

    // R7: never settles
    for (int i = 0; i < 40; i++) script[i] = i[0] ? 8'h02 : 8'h47;
    slen = 40;
    run(2'd0, AW'(19'h1234), 8'hA5, 0);
    chk(nr == MAXP + 1, "R7", "timeout read count", nr, MAXP + 1);

    // R8: every read-back wrong
    script[0] = 8'hA4; slen = 1;
    run(2'd0, AW'(19'h0777), 8'hA5, 0);
    chk(rsp_data[7:0] == 8'hA4 && nr == 7, "R8", "mismatch after three reads", nr, 7);

    // R8: first read-back wrong, retries good
    for (int i = 0; i < 8; i++) script[i] = 8'hA5;
    script[4] = 8'hA4; slen = 8;
    run(2'd0, AW'(19'h0778), 8'hA5, 0);

    // R6: false settle broken by a confirming read (chip erase)
    script[0] = 8'h40; script[1] = 8'h00; script[2] = 8'h00; script[3] = 8'h40;
    script[4] = 8'h00; slen = 5;
    run(2'd2, AW'(19'h7FFFF), 8'h00, 0);
    chk(nr == 8, "R6", "false settle read count", nr, 8);

    // R3: sector address with low bits set
    script[0] = 8'hFF; slen = 1;
    run(2'd1, AW'(19'h4ABCD), 8'h00, 0);

    // R5 and R9: identify with a request held during the busy time
    run(2'd3, AW'(19'h12345), 8'h00, 1);

    for (int k = 0; k < 36; k++) begin
      op = 2'($urandom % 4);
      d  = 8'($urandom);
      b  = $urandom % 12;
      for (int i = 0; i < b; i++) begin
        v = 8'($urandom); v[6] = ~i[0]; script[i] = v;
      end
      t6 = 1'($urandom);
      for (int i = b; i < b + 8; i++) begin
        if (op == 2'd0) v = ($urandom % 3 == 0) ? (d ^ 8'h01) : d;
        else begin v = 8'($urandom); v[6] = t6; end
        script[i] = v;
      end
      slen = b + 8;
      id0 = 8'($urandom); id1 = 8'($urandom);
      run(op, AW'($urandom), d, ($urandom % 4) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule